// File: doc/BRIEF.md
# Anode Brightness and Blink Modulator

This block sits between the pattern fetch and the anode drivers of a dot-matrix fluorescent display scanner. In each grid time slot it receives the raw dot pattern for the digit being scanned, one character cell per display line. It returns the anode levels for that slot. Those levels are gated by a display-enable flag, a line-count mode and a 2-bit brightness code that shortens the anode pulse inside each slot. A cursor overlay and a blinking cursor character are also applied.

The block owns the timebase. A slot counter divides the system clock into grid slots, and each slot is cut into four equal quarters. The block puts out a one-cycle pulse at the start of every slot so that a grid sequencer can advance. A slower divider counts slots and flips a blink phase, which gives the cursor-blink rate. Both lengths are parameters, so that short periods can be used in test.

Top module: `dotmod_top`

## Requirements
- R1: While `rst_n` is low, `anode` is all zeros. After reset the active brightness is full (code 0), the blink phase is 0 and the block is in the first cycle of a slot.
- R2: A slot lasts 4*SUB_LEN cycles and is split into four quarters of SUB_LEN cycles. With active brightness code c, anodes may be lit only during the first 4-c quarters: code 0 gives 4 quarters, 1 gives 3, 2 gives 2 and 3 gives 1.
- R3: A new `bright_code` is sampled only in the last cycle of a slot and applies from the next slot on. A mid-slot change never alters the current slot.
- R4: With `disp_on` low, every anode output is 0.
- R5: Cell k occupies `anode[k*CELL +: CELL]` and `dots[k*CELL +: CELL]`, where CELL = COLS*ROWS. Dot (row r, column c) is bit r*COLS+c, and row ROWS-1 is the bottom. With `two_line` low, every cell above cell 0 is held at 0.
- R6: With `cursor_on` high and `cur_hit[k]` high, the bottom row of cell k is forced on and the other dots pass through.
- R7: `blink_phase` toggles at every BLINK_SLOTS-th slot boundary. While it is 1 and `blink_on` is high, a cell with `cur_hit[k]` set shows all dots on. Otherwise that cell shows its normal (cursor-overlaid) pattern.
- R8: `slot_tick` is high in exactly the first cycle of each slot, once every 4*SUB_LEN cycles.
- R9: A cell whose `cur_hit` bit is low passes its dots unchanged, whatever the cursor and blink settings are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dots | input | LINES*COLS*ROWS | Raw dot pattern of the scanned digit, one cell per line |
| bright_code | input | 2 | Brightness code: 0 full, 1 three quarters, 2 half, 3 one quarter |
| disp_on | input | 1 | Display enable |
| two_line | input | 1 | 1: all lines driven; 0: only line 0 driven |
| cursor_on | input | 1 | Cursor underline enable |
| blink_on | input | 1 | Cursor-character blink enable |
| cur_hit | input | LINES | Cell k of this digit is the cursor position |
| anode | output | LINES*COLS*ROWS | Gated anode levels |
| slot_tick | output | 1 | First cycle of a grid slot |
| blink_phase | output | 1 | Current blink phase (1: all-on half) |

## Verification
The properties assume two things about the inputs. The pattern, mode and cursor inputs may change in any cycle, since the anode path is combinational from them. `bright_code` is allowed to move mid-slot, and the properties rely on the slot latch, not on the stimulus, to keep pulses whole. The stimulus therefore changes every input away from the clock edge. In the boundary case it changes `bright_code` in the middle of a slot, and it sets `cur_hit` to each combination of cells. The reference model in the bench starts its own slot and blink counters at reset release, and each output is compared against that model.

// File: rtl/dotmod_pkg.sv
package dotmod_pkg;

  typedef logic [1:0] bright_t;
  typedef logic [1:0] quarter_t;

  // number of lit quarters for a brightness code
  function automatic logic [2:0] lit_quarters(input bright_t code);
    return 3'd4 - {1'b0, code};
  endfunction

  // whether quarter q of a slot carries anode drive for the given code
  function automatic logic quarter_on(input quarter_t q, input bright_t code);
    return {1'b0, q} < lit_quarters(code);
  endfunction

  // safe counter width for a modulus of n (at least 1 bit)
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/dotmod_slot_timer.sv
module dotmod_slot_timer
  import dotmod_pkg::*;
#(
  parameter int SUB_LEN = 1000
) (
  input  logic     clk,
  input  logic     rst_n,
  output quarter_t quarter,
  output logic     slot_first,
  output logic     slot_last
);
  localparam int SUB_W = cnt_width(SUB_LEN);
  localparam logic [SUB_W-1:0] SUB_MAX = SUB_W'(SUB_LEN - 1);

  logic [SUB_W-1:0] sub_cnt;
  logic             sub_wrap;

  assign sub_wrap = (sub_cnt == SUB_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_cnt <= '0;
      quarter <= '0;
    end else begin
      if (sub_wrap) begin
        sub_cnt <= '0;
        quarter <= quarter + 2'd1;
      end else begin
        sub_cnt <= sub_cnt + 1'b1;
      end
    end
  end

  assign slot_first = (sub_cnt == '0) && (quarter == 2'd0);
  assign slot_last  = sub_wrap && (quarter == 2'd3);

endmodule

// File: rtl/dotmod_pwm_gate.sv
module dotmod_pwm_gate
  import dotmod_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  bright_t  bright_code,
  input  logic     slot_last,
  input  quarter_t quarter,
  output logic     pulse_en
);
  bright_t bright_q;

  // brightness is only taken at a slot boundary so no partial pulses appear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bright_q <= '0;
    end else if (slot_last) begin
      bright_q <= bright_code;
    end
  end

  assign pulse_en = quarter_on(quarter, bright_q);

endmodule

// File: rtl/dotmod_blink_div.sv
module dotmod_blink_div
  import dotmod_pkg::*;
#(
  parameter int BLINK_SLOTS = 6250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_last,
  output logic phase
);
  localparam int BLK_W = cnt_width(BLINK_SLOTS);
  localparam logic [BLK_W-1:0] BLK_MAX = BLK_W'(BLINK_SLOTS - 1);

  logic [BLK_W-1:0] slots;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slots <= '0;
      phase <= 1'b0;
    end else if (slot_last) begin
      if (slots == BLK_MAX) begin
        slots <= '0;
        phase <= ~phase;
      end else begin
        slots <= slots + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dotmod_cell_shaper.sv
module dotmod_cell_shaper #(
  parameter int COLS = 5,
  parameter int ROWS = 8
) (
  input  logic [COLS*ROWS-1:0] raw,
  input  logic                 drive,
  input  logic                 cursor_on,
  input  logic                 blink_on,
  input  logic                 blink_phase,
  input  logic                 is_cursor,
  output logic [COLS*ROWS-1:0] lit
);
  localparam int CELL = COLS * ROWS;
  localparam logic [CELL-1:0] UNDERLINE = {COLS{1'b1}} << (COLS * (ROWS - 1));

  logic [CELL-1:0] shaped;

  always_comb begin
    shaped = raw;
    if (is_cursor) begin
      if (blink_on && blink_phase) begin
        shaped = '1;
      end else if (cursor_on) begin
        shaped = raw | UNDERLINE;
      end
    end
  end

  assign lit = drive ? shaped : '0;

endmodule

// File: rtl/dotmod_top.sv
module dotmod_top
  import dotmod_pkg::*;
#(
  parameter int COLS        = 5,
  parameter int ROWS        = 8,
  parameter int LINES       = 2,
  parameter int SUB_LEN     = 1000,
  parameter int BLINK_SLOTS = 6250
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [LINES*COLS*ROWS-1:0]   dots,
  input  logic [1:0]                   bright_code,
  input  logic                         disp_on,
  input  logic                         two_line,
  input  logic                         cursor_on,
  input  logic                         blink_on,
  input  logic [LINES-1:0]             cur_hit,
  output logic [LINES*COLS*ROWS-1:0]   anode,
  output logic                         slot_tick,
  output logic                         blink_phase
);
  localparam int CELL = COLS * ROWS;

  quarter_t quarter;
  logic     slot_last;
  logic     pulse_en;
  logic     base_drive;

  dotmod_slot_timer #(.SUB_LEN(SUB_LEN)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .quarter    (quarter),
    .slot_first (slot_tick),
    .slot_last  (slot_last)
  );

  dotmod_pwm_gate u_pwm (
    .clk         (clk),
    .rst_n       (rst_n),
    .bright_code (bright_code),
    .slot_last   (slot_last),
    .quarter     (quarter),
    .pulse_en    (pulse_en)
  );

  dotmod_blink_div #(.BLINK_SLOTS(BLINK_SLOTS)) u_blink (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_last (slot_last),
    .phase     (blink_phase)
  );

  assign base_drive = rst_n && disp_on && pulse_en;

  for (genvar k = 0; k < LINES; k++) begin : g_cell
    logic line_en;
    if (k == 0) begin : g_first
      assign line_en = 1'b1;
    end else begin : g_rest
      assign line_en = two_line;
    end

    dotmod_cell_shaper #(.COLS(COLS), .ROWS(ROWS)) u_shape (
      .raw         (dots[k*CELL +: CELL]),
      .drive       (base_drive && line_en),
      .cursor_on   (cursor_on),
      .blink_on    (blink_on),
      .blink_phase (blink_phase),
      .is_cursor   (cur_hit[k]),
      .lit         (anode[k*CELL +: CELL])
    );
  end

endmodule

// File: rtl/dotmod_checker.sv
module dotmod_checker #(
  parameter int COLS     = 5,
  parameter int ROWS     = 8,
  parameter int LINES    = 2,
  parameter int SLOT_LEN = 4000
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [LINES*COLS*ROWS-1:0] anode,
  input logic                       disp_on,
  input logic                       two_line,
  input logic                       cursor_on,
  input logic [LINES-1:0]           cur_hit,
  input logic                       slot_tick,
  input logic                       blink_phase,
  input logic                       pulse_en
);
  localparam int CELL = COLS * ROWS;
  localparam int CW   = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;

  logic [CW-1:0] since_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_tick <= '0;
    else if (since_tick == CW'(SLOT_LEN - 1)) since_tick <= '0;
    else since_tick <= since_tick + 1'b1;
  end

  // R8: slot start pulse recurs every SLOT_LEN cycles
  a_r8_tick_period: assert property (@(posedge clk) disable iff (!rst_n)
    slot_tick == (since_tick == '0));

  // R2/R3: anode enable only opens at the start of a slot
  a_r3_no_mid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_en) |-> slot_tick);

  // R2: every code lights at least the first quarter
  a_r2_first_quarter_lit: assert property (@(posedge clk) disable iff (!rst_n)
    slot_tick |-> pulse_en);

  // R4: display off blanks everything
  a_r4_display_off: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |-> (anode == '0));

  // R5: one-line mode leaves upper cells dark
  a_r5_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    !two_line |-> (anode[LINES*CELL-1:CELL] == '0));

  // R6: cursor underline lit on cell 0 whenever drive is active
  a_r6_cursor_row: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_on && cursor_on && cur_hit[0] && pulse_en)
      |-> (anode[COLS*(ROWS-1) +: COLS] == {COLS{1'b1}}));

  // R7: blink phase only moves at a slot boundary
  a_r7_phase_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_tick |-> $stable(blink_phase));

endmodule

bind dotmod_top dotmod_checker #(
  .COLS(COLS), .ROWS(ROWS), .LINES(LINES), .SLOT_LEN(4 * SUB_LEN)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .anode       (anode),
  .disp_on     (disp_on),
  .two_line    (two_line),
  .cursor_on   (cursor_on),
  .cur_hit     (cur_hit),
  .slot_tick   (slot_tick),
  .blink_phase (blink_phase),
  .pulse_en    (pulse_en)
);

// File: tb/dotmod_top_tb.sv
module dotmod_top_tb;
  localparam int COLS  = 5;
  localparam int ROWS  = 8;
  localparam int LINES = 2;
  localparam int SUB   = 2;
  localparam int BLK   = 3;
  localparam int CELL  = COLS * ROWS;
  localparam int W     = LINES * CELL;
  localparam int SLOT  = 4 * SUB;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n;
  logic [W-1:0]     dots;
  logic [1:0]       bright_code;
  logic             disp_on, two_line, cursor_on, blink_on;
  logic [LINES-1:0] cur_hit;
  logic [W-1:0]     anode;
  logic             slot_tick, blink_phase;

  dotmod_top #(
    .COLS(COLS), .ROWS(ROWS), .LINES(LINES), .SUB_LEN(SUB), .BLINK_SLOTS(BLK)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .dots(dots), .bright_code(bright_code),
    .disp_on(disp_on), .two_line(two_line), .cursor_on(cursor_on),
    .blink_on(blink_on), .cur_hit(cur_hit), .anode(anode),
    .slot_tick(slot_tick), .blink_phase(blink_phase)
  );

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  bit    done = 1'b0;

  // reference model of slot position, active brightness and blink phase
  int m_cnt = 0, m_br = 0, m_slots = 0;
  bit m_phase = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= 0; m_br <= 0; m_slots <= 0; m_phase <= 1'b0;
    end else begin
      m_cnt <= (m_cnt == SLOT - 1) ? 0 : m_cnt + 1;
      if (m_cnt == SLOT - 1) begin
        m_br <= int'(bright_code);
        if (m_slots == BLK - 1) begin
          m_slots <= 0;
          m_phase <= !m_phase;
        end else begin
          m_slots <= m_slots + 1;
        end
      end
    end
  end

  function automatic logic [W-1:0] expect_anode();
    logic [W-1:0]    r;
    logic [CELL-1:0] p;
    bit              en;
    r = '0;
    for (int l = 0; l < LINES; l++) begin
      p = dots[l*CELL +: CELL];
      if (cur_hit[l] && blink_on && m_phase) p = '1;
      else if (cur_hit[l] && cursor_on) p = p | (CELL'(5'h1F) << (COLS * (ROWS - 1)));
      en = rst_n && disp_on && ((m_cnt / SUB) < (4 - m_br)) && (l == 0 || two_line);
      if (en) r[l*CELL +: CELL] = p;
    end
    return r;
  endfunction

  task automatic step();
    logic [W-1:0] e;
    @(posedge clk);
    #5;
    e = expect_anode();
    checks++;
    if (anode !== e) begin
      errors++;
      $display("FAIL %s anode actual=%h expected=%h", tag, anode, e);
    end
    checks++;
    if (slot_tick !== (m_cnt == 0)) begin
      errors++;
      $display("FAIL R8 slot_tick actual=%b expected=%b", slot_tick, (m_cnt == 0));
    end
    checks++;
    if (blink_phase !== m_phase) begin
      errors++;
      $display("FAIL R7 blink_phase actual=%b expected=%b", blink_phase, m_phase);
    end
  endtask

  task automatic run(input int n, input bit fresh);
    for (int i = 0; i < n; i++) begin
      if (fresh) dots = W'({$urandom, $urandom, $urandom});
      step();
    end
  endtask

  initial begin
    rst_n = 1'b0; dots = '1; bright_code = 2'd3; disp_on = 1'b1;
    two_line = 1'b1; cursor_on = 1'b0; blink_on = 1'b0; cur_hit = '0;
    // R1: outputs dark during reset, and full brightness in the first slot after it
    tag = "R1";
    run(3, 1'b0);
    rst_n = 1'b1;
    run(SLOT, 1'b1);

    // R2: sweep all brightness codes over several slots
    tag = "R2";
    for (int c = 0; c < 4; c++) begin
      bright_code = 2'(c);
      run(3 * SLOT, 1'b1);
    end

    // R3: change mid-slot, only next slot may reflect it
    tag = "R3";
    bright_code = 2'd0;
    run(SLOT + 3, 1'b1);
    bright_code = 2'd3;
    run(2 * SLOT, 1'b1);
    bright_code = 2'd1;
    run(SLOT + 5, 1'b1);
    bright_code = 2'd0;
    run(SLOT, 1'b1);

    // R4: display off
    tag = "R4";
    disp_on = 1'b0;
    run(2 * SLOT, 1'b1);
    disp_on = 1'b1;

    // R5: one-line mode
    tag = "R5";
    two_line = 1'b0;
    run(2 * SLOT, 1'b1);
    two_line = 1'b1;

    // R6: underline on each cell combination
    tag = "R6";
    cursor_on = 1'b1;
    for (int h = 1; h < 4; h++) begin
      cur_hit = 2'(h);
      dots = '0;
      run(SLOT, 1'b0);
      run(SLOT, 1'b1);
    end

    // R9: no cursor cell means untouched patterns
    tag = "R9";
    cur_hit = '0;
    blink_on = 1'b1;
    run(2 * BLK * SLOT, 1'b1);

    // R7: blink across several phase changes
    tag = "R7";
    cur_hit = 2'b01;
    run(2 * BLK * SLOT, 1'b1);
    cursor_on = 1'b0;
    cur_hit = 2'b11;
    bright_code = 2'd2;
    run(2 * BLK * SLOT, 1'b1);
    blink_on = 1'b0;
    run(BLK * SLOT, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule